// File: doc/BRIEF.md
# Banked Window Paging Controller

This block sits on an 8-bit CPU bus and manages a 16 KB paged window at 0x8000–0xBFFF. A single select register at 0xFE30 holds a 4-bit bank number and an overlay-enable flag. Every window access is steered to one of 16 banks. While the overlay flag is set, the lowest 4 KB of the window goes to a private overlay RAM instead. Each bank is either read-only or writable, fixed by a parameter. Read-only banks return a computed pattern. Writable banks and the overlay are small on-chip arrays.

Software pages a bank in by writing the select register. Each write replaces the bank number and the overlay flag together. A read of the register returns the stored byte exactly, so code can read it, modify it and write it back without losing the overlay state. The storage is deliberately small. Each bank keeps only the two address bits that choose the 4 KB quarter of the window, plus the low LOW_AW address bits. All other offset bits alias.

Top module: `bank_window_ctrl`

## Requirements
- R1: After reset the select register reads 0x00. Bank 0 is selected and the overlay is paged out.
- R2: The select register's bits 3:0 choose the bank. With bit 7 clear, every window address from 0x8000 to 0xBFFF reaches that bank.
- R3: With bit 7 set, reads and writes at 0x8000–0x8FFF use the overlay RAM. Such a write leaves every bank unchanged.
- R4: With bit 7 set, addresses from 0x9000 to 0xBFFF still reach the selected bank.
- R5: A read of 0xFE30 returns the full last-written byte. Bits 6:4 are kept and returned, but they do not affect decoding.
- R6: Each write to 0xFE30 replaces the bank number and bit 7 together. A write with bit 7 clear hides the overlay. The overlay keeps its contents and shows them again once bit 7 is set.
- R7: Bank k accepts writes only when bit k of BANK_WRITABLE is 1. The default value is 0xAAAA, so the odd banks are writable. Writes to any other bank are ignored. A read-only bank returns `(k*37 XOR i*3 XOR 0x5A) mod 256` at storage index i.
- R8: The select register changes on the clock edge of its write cycle. The very next access uses the new mapping.
- R9: An access outside 0x8000–0xBFFF that is not to 0xFE30 keeps bus_cs low and bus_rdata at 0x00.
- R10: The bank storage index is {addr[13:12], addr[LOW_AW-1:0]}, with LOW_AW = 4 by default. The overlay index is addr[LOW_AW-1:0]. The other address bits alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | An access is presented this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Access address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; 0x00 when not claimed |
| bus_cs | output | 1 | High when this block claims the access |

## Verification
The hardest case is overlay RAM and a writable bank that share the same address range. A write there must land in exactly one of them, and the other must keep its old value, visible only after the overlay flag is toggled. The bench first fills every writable bank and the overlay with known data. Directed sequences then write through the overlay, clear bit 7 and read the bank underneath, then set bit 7 again to show that the overlay data survived. Random traffic mixes select writes with window traffic so that flips of the overlay flag land between reads and writes to both regions.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  localparam int NBANK = 16;
  localparam logic [15:0] SEL_ADDR = 16'hFE30;

  // bit 7 overlay enable, bits 6:4 kept only for readback, bits 3:0 bank
  typedef struct packed {
    logic       ov_en;
    logic [2:0] spare;
    logic [3:0] bank;
  } sel_t;

  // contents of a read-only bank, computed from bank number and index
  function automatic logic [7:0] rom_byte(input logic [3:0] bank, input logic [7:0] idx);
    return (8'(bank) * 8'd37) ^ (idx * 8'd3) ^ 8'h5A;
  endfunction
endpackage

// File: rtl/bwc_sel_reg.sv
module bwc_sel_reg
  import bwc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic [7:0] wdata,
  output sel_t sel_q
);
  sel_t sel_d;

  always_comb begin
    sel_d = sel_q;
    if (wr_en) sel_d = sel_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else if (wr_en) sel_q <= sel_d;
  end
endmodule

// File: rtl/bwc_decode.sv
module bwc_decode
  import bwc_pkg::*;
#(
  parameter int LOW_AW = 4,
  localparam int IDX_W = LOW_AW + 2
) (
  input  logic             valid,
  input  logic             we,
  input  logic [15:0]      addr,
  input  logic [3:0]       sel_bank,
  input  logic             ov_en,
  output logic             cs,
  output logic             hit_sel,
  output logic             to_ov,
  output logic             sel_we,
  output logic             ov_we,
  output logic [NBANK-1:0] bank_we,
  output logic [IDX_W-1:0] idx
);
  logic hit_win, lower_4k, win_wr;

  always_comb begin
    hit_sel  = (addr == SEL_ADDR);
    hit_win  = (addr[15:14] == 2'b10);
    lower_4k = (addr[13:12] == 2'b00);
    to_ov    = hit_win && lower_4k && ov_en;
    cs       = valid && (hit_sel || hit_win);
    sel_we   = valid && we && hit_sel;
    win_wr   = valid && we && hit_win;
    ov_we    = win_wr && to_ov;
    idx      = {addr[13:12], addr[LOW_AW-1:0]};
    bank_we  = '0;
    if (win_wr && !to_ov) bank_we[sel_bank] = 1'b1;
  end
endmodule

// File: rtl/bwc_bank_store.sv
module bwc_bank_store
  import bwc_pkg::*;
#(
  parameter int LOW_AW = 4,
  parameter logic [NBANK-1:0] WRITABLE = 16'hAAAA,
  localparam int IDX_W = LOW_AW + 2,
  localparam int DEPTH = 1 << IDX_W,
  localparam int OV_DEPTH = 1 << LOW_AW
) (
  input  logic             clk,
  input  logic [NBANK-1:0] bank_we,
  input  logic             ov_we,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wdata,
  input  logic [3:0]       rd_bank,
  output logic [7:0]       bank_rdata,
  output logic [7:0]       ov_rdata
);
  logic [NBANK-1:0][7:0] rd_arr;
  logic [7:0] ov_mem [OV_DEPTH];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    if (WRITABLE[b]) begin : g_ram
      logic [7:0] mem [DEPTH];
      always_ff @(posedge clk) begin
        if (bank_we[b]) mem[idx] <= wdata;
      end
      assign rd_arr[b] = mem[idx];
    end else begin : g_rom
      logic rom_unused_we;
      assign rom_unused_we = bank_we[b];
      assign rd_arr[b] = rom_byte(4'(b), 8'(idx));
    end
  end

  always_ff @(posedge clk) begin
    if (ov_we) ov_mem[idx[LOW_AW-1:0]] <= wdata;
  end

  assign ov_rdata   = ov_mem[idx[LOW_AW-1:0]];
  assign bank_rdata = rd_arr[rd_bank];
endmodule

// File: rtl/bank_window_ctrl.sv
module bank_window_ctrl
  import bwc_pkg::*;
#(
  parameter int LOW_AW = 4,
  parameter logic [15:0] BANK_WRITABLE = 16'hAAAA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_we,
  input  logic [15:0] bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        bus_cs
);
  localparam int IDX_W = LOW_AW + 2;

  sel_t             sel_q;
  logic             hit_sel, to_ov, sel_we, ov_we;
  logic [NBANK-1:0] bank_we;
  logic [IDX_W-1:0] idx;
  logic [7:0]       bank_rdata, ov_rdata;

  bwc_sel_reg u_sel (
    .clk(clk), .rst_n(rst_n), .wr_en(sel_we), .wdata(bus_wdata), .sel_q(sel_q)
  );

  bwc_decode #(.LOW_AW(LOW_AW)) u_dec (
    .valid(bus_valid), .we(bus_we), .addr(bus_addr),
    .sel_bank(sel_q.bank), .ov_en(sel_q.ov_en),
    .cs(bus_cs), .hit_sel(hit_sel), .to_ov(to_ov), .sel_we(sel_we),
    .ov_we(ov_we), .bank_we(bank_we), .idx(idx)
  );

  bwc_bank_store #(.LOW_AW(LOW_AW), .WRITABLE(BANK_WRITABLE)) u_store (
    .clk(clk), .bank_we(bank_we), .ov_we(ov_we), .idx(idx), .wdata(bus_wdata),
    .rd_bank(sel_q.bank), .bank_rdata(bank_rdata), .ov_rdata(ov_rdata)
  );

  always_comb begin
    if (!bus_cs)      bus_rdata = 8'h00;
    else if (hit_sel) bus_rdata = sel_q;
    else if (to_ov)   bus_rdata = ov_rdata;
    else              bus_rdata = bank_rdata;
  end
endmodule

// File: rtl/bwc_checker.sv
module bwc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_we,
  input logic [15:0] bus_addr,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  bus_rdata,
  input logic        bus_cs,
  input logic [7:0]  sel_q,
  input logic [15:0] bank_we,
  input logic        ov_we
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_clear: assert (sel_q == 8'h00);
    end
  end

  a_r5_store_all_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we && bus_addr == 16'hFE30) |=> (sel_q == $past(bus_wdata)));

  a_r5_read_port: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_we && bus_addr == 16'hFE30) |-> (bus_cs && bus_rdata == sel_q));

  a_r3_overlay_steer: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we && bus_addr[15:12] == 4'h8 && sel_q[7]) |-> (ov_we && bank_we == 16'h0));

  a_r4_upper_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we && bus_addr[15:14] == 2'b10 && bus_addr[13:12] != 2'b00)
    |-> (!ov_we && bank_we == (16'h1 << sel_q[3:0])));

  a_r2_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));

  a_r9_no_claim: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[15:14] != 2'b10 && bus_addr != 16'hFE30) |-> (!bus_cs && bus_rdata == 8'h00));
endmodule

bind bank_window_ctrl bwc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_cs(bus_cs), .sel_q(sel_q), .bank_we(bank_we), .ov_we(ov_we)
);

// File: tb/bank_window_ctrl_tb.sv
module bank_window_ctrl_tb;
  localparam logic [15:0] WR_MASK = 16'hAAAA;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic bus_valid = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_cs;

  int n_chk = 0, n_err = 0;
  logic [7:0] m_ram [16][64];
  logic [7:0] m_ov [16];
  logic [7:0] m_sel = 8'h00;

  always #4 clk = ~clk;

  bank_window_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_cs(bus_cs)
  );

  function automatic logic [7:0] rom_exp(int b, int i);
    return 8'((b * 37) ^ (i * 3) ^ 8'h5A);
  endfunction

  function automatic int idx_of(logic [15:0] a);
    return {a[13:12], a[3:0]};
  endfunction

  function automatic logic [8:0] exp_read(logic [15:0] a);
    int b;
    if (a == 16'hFE30) return {1'b1, m_sel};
    if (a[15:14] != 2'b10) return 9'h000;
    if (a[13:12] == 2'b00 && m_sel[7]) return {1'b1, m_ov[a[3:0]]};
    b = int'(m_sel[3:0]);
    if (WR_MASK[b]) return {1'b1, m_ram[b][idx_of(a)]};
    return {1'b1, rom_exp(b, idx_of(a))};
  endfunction

  function automatic void m_write(logic [15:0] a, logic [7:0] d);
    int b;
    if (a == 16'hFE30) m_sel = d;
    else if (a[15:14] == 2'b10) begin
      b = int'(m_sel[3:0]);
      if (a[13:12] == 2'b00 && m_sel[7]) m_ov[a[3:0]] = d;
      else if (WR_MASK[b]) m_ram[b][idx_of(a)] = d;
    end
  endfunction

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got cs/data %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_valid = 1'b0; bus_we = 1'b0;
    m_write(a, d);
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    #2;
    chk(tag, {bus_cs, bus_rdata}, exp_read(a));
    @(posedge clk);
    #1;
    bus_valid = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] a;
    logic [31:0] r;
    void'($urandom(32'd2024));
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(16'hFE30, "R1 select after reset");
    rd(16'h8000, "R1 bank 0 after reset");

    // fill writable banks and overlay with known data
    for (int b = 0; b < 16; b++) begin
      if (WR_MASK[b]) begin
        wr(16'hFE30, 8'(b));
        for (int i = 0; i < 64; i++) begin
          a = {2'b10, 2'(i >> 4), 8'h00, 4'(i)};
          wr(a, 8'($urandom));
        end
      end
    end
    wr(16'hFE30, 8'h80);
    for (int j = 0; j < 16; j++) wr(16'h8000 | 16'(j), 8'($urandom));

    // R2 bank choice, whole window with bit 7 clear
    wr(16'hFE30, 8'h03);
    wr(16'h8005, 8'hC3);
    rd(16'h8005, "R2 lower quarter bank 3");
    rd(16'hB005, "R2 upper quarter bank 3");
    wr(16'hFE30, 8'h02);
    rd(16'hA007, "R2 read-only bank 2");

    // R8 mapping used by the very next access
    wr(16'hFE30, 8'h05);
    rd(16'h9001, "R8 next cycle uses bank 5");

    // R3 overlay takes lower 4K, bank untouched
    wr(16'hFE30, 8'h85);
    wr(16'h8002, 8'h11);
    rd(16'h8002, "R3 overlay read");
    wr(16'hFE30, 8'h05);
    rd(16'h8002, "R3 bank 5 unchanged under overlay");

    // R4 upper 12K stays with bank while overlay active
    wr(16'hFE30, 8'h87);
    wr(16'h9003, 8'h77);
    rd(16'h9003, "R4 upper window bank 7");
    rd(16'hA003, "R4 upper window bank 7 second quarter");

    // R6 paging out hides overlay, paging in restores it
    wr(16'hFE30, 8'h07);
    rd(16'h8002, "R6 overlay hidden");
    wr(16'hFE30, 8'h87);
    rd(16'h8002, "R6 overlay retained");

    // R5 full readback, spare bits ignored by decode
    wr(16'hFE30, 8'h75);
    rd(16'hFE30, "R5 readback 0x75");
    rd(16'h9001, "R5 spare bits do not alter bank 5");
    rd(16'h8002, "R5 spare bits do not alter overlay state");

    // R7 read-only banks ignore writes, writable banks accept
    wr(16'hFE30, 8'h04);
    wr(16'h8006, 8'hEE);
    rd(16'h8006, "R7 read-only bank 4 ignores write");
    wr(16'hFE30, 8'h09);
    wr(16'h8006, 8'hEE);
    rd(16'h8006, "R7 writable bank 9 accepts write");

    // R9 unclaimed addresses
    rd(16'h7FFF, "R9 below window");
    rd(16'hC000, "R9 above window");
    rd(16'hFE31, "R9 next to select");
    rd(16'h0000, "R9 zero page");

    // R10 aliasing of storage index
    wr(16'hFE30, 8'h01);
    wr(16'h8FF4, 8'h3C);
    rd(16'h8004, "R10 bank alias of 0x8FF4");
    wr(16'hFE30, 8'h81);
    wr(16'h8A0C, 8'h4D);
    rd(16'h800C, "R10 overlay alias of 0x8A0C");

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      r = $urandom;
      if (r[3:0] < 4'd3) wr(16'hFE30, r[15:8]);
      else if (r[3:0] < 4'd8) wr({2'b10, r[29:16]}, r[15:8]);
      else if (r[3:0] < 4'd14) rd({2'b10, r[29:16]}, "R2 random window read");
      else begin
        a = r[31:16];
        if (a[15:14] == 2'b10) a[15] = 1'b0;
        if (a == 16'hFE30) a = 16'h0000;
        if (r[4]) rd(16'hFE30, "R5 random readback");
        else rd(a, "R9 random unclaimed");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule